// File: doc/BRIEF.md
# Flash Word-Program Command and Status Controller

This block models the command side of a NOR-style flash device. Bus writes are taken as command bytes. A word program takes two bus writes: a setup code, then the target address with its data. The program is carried out by an internal write engine that counts down a fixed number of clock cycles. Programming can only clear bits, so the stored word becomes the old word ANDed with the data. Storage is a small on-chip register array that resets to all ones. Per-block lock inputs, a supply-valid input and a failure-injection input decide whether an attempt aborts or fails.

An 8-bit status word reports four things: whether the engine is ready, a failed program, an invalid supply, and a locked target. It also shows when a program is suspended. A read-mode selector decides what a read strobe returns: array data, the status word, or identifier words. While the engine runs, only a few commands are accepted. A program can be suspended and later resumed.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset the read mode is array, every array word reads as all ones, and the status word reads 0x80.
- R2: A completed program makes the target word equal to its previous value ANDed with the written data. A bit that is 0 never returns to 1.
- R3: From the setup write onward, every read returns the status word, whatever the address, until a different read-mode command is written.
- R4: Bit 7 of the status word is 0 while the engine runs and 1 otherwise. The engine is busy from the data write for exactly PROG_CYC cycles.
- R5: If the supply-valid input is low at the data write, status bit 3 is set, the engine does not start and the array is unchanged.
- R6: If the target block's lock input is high at the data write, status bit 1 is set, the engine does not start and the array is unchanged. The block index is the top BLK_W address bits.
- R7: If the failure-injection input is high when the countdown ends, status bit 4 is set and the array word is left unchanged.
- R8: Status bits 4, 3 and 1 stay set until command 0x50 is written while the engine is idle. That command clears all three.
- R9: While the engine runs, commands 0x40 and 0x50 are ignored. Command 0xFF makes array reads return the FILL pattern until the engine stops.
- R10: Command 0xB0 during a run pauses the countdown, and the status word reads bit 7 and bit 2 set (0x84). Command 0xD0 resumes the run for the remaining cycles. If 0xB0 arrives in the final countdown cycle, completion wins and no suspend occurs.
- R11: After command 0x90, reads return MFR_ID when address bit 0 is 0 and DEV_ID when it is 1.
- R12: The read data output is registered. It updates on the clock edge that samples the read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Word address for reads and writes |
| bus_wdata | input | DATA_W | Write data; the low byte is the command code |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| vpp_ok | input | 1 | Programming supply within range |
| blk_lock | input | 2**BLK_W | Per-block lock bits |
| fail_inj | input | 1 | Forces a program failure at completion |

## Verification
Two events can land in the same cycle: the engine's countdown completing and a suspend command being written. To provoke this, the bench writes 0xB0 exactly on the edge where the countdown ends, counted from the data write. It then judges the outcome in three ways: the status reads 0x80 with bit 2 clear, the array word holds the programmed value, and no resume is needed.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_BUSY, ST_SUSP} fpc_state_e;
    typedef enum logic [1:0] {RD_ARRAY, RD_STATUS, RD_IDENT} fpc_rmode_e;

    localparam logic [7:0] CMD_PROG   = 8'h40;
    localparam logic [7:0] CMD_RDSR   = 8'h70;
    localparam logic [7:0] CMD_CLRSR  = 8'h50;
    localparam logic [7:0] CMD_IDENT  = 8'h90;
    localparam logic [7:0] CMD_RDARR  = 8'hFF;
    localparam logic [7:0] CMD_SUSP   = 8'hB0;
    localparam logic [7:0] CMD_RESUME = 8'hD0;
endpackage

// File: rtl/fpc_array.sv
module fpc_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word,
    input  logic              prog_en,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    output logic [DATA_W-1:0] old_word
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    assign rd_word  = mem_q[rd_addr];
    assign old_word = mem_q[prog_addr];

    always_comb begin
        mem_d = mem_q;
        if (prog_en) mem_d[prog_addr] = mem_q[prog_addr] & prog_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else begin
            mem_q <= mem_d;
        end
    end

    // R2
    and_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |=> (mem_q[$past(prog_addr)] == ($past(old_word) & $past(prog_data))));
endmodule

// File: rtl/fpc_timer.sv
module fpc_timer #(
    parameter int PROG_CYC = 8,
    localparam int CW = $clog2(PROG_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);
    logic [CW-1:0] cnt_q, cnt_d;

    assign done = run && (cnt_q == CW'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (load)                     cnt_d = CW'(PROG_CYC);
        else if (run && cnt_q != '0)  cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(PROG_CYC));
    // R10
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl #(
    parameter int              ADDR_W   = 6,
    parameter int              DATA_W   = 16,
    parameter int              BLK_W    = 2,
    parameter int              PROG_CYC = 8,
    parameter logic [15:0]     MFR_ID   = 16'h0051,
    parameter logic [15:0]     DEV_ID   = 16'h7E21,
    parameter logic [15:0]     FILL     = 16'hDEAD,
    localparam int             NBLK     = 1 << BLK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              vpp_ok,
    input  logic [NBLK-1:0]   blk_lock,
    input  logic              fail_inj
);
    import fpc_pkg::*;

    typedef struct packed {
        fpc_state_e        state;
        fpc_rmode_e        rmode;
        logic              sr_pfail;
        logic              sr_vpp;
        logic              sr_lock;
        logic [ADDR_W-1:0] tgt_addr;
        logic [DATA_W-1:0] tgt_data;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t q, d;
    logic              tmr_load, tmr_run, tmr_done, prog_en;
    logic [DATA_W-1:0] arr_word, old_word;
    logic [7:0]        cmd, status;
    logic [BLK_W-1:0]  blk;

    assign cmd       = bus_wdata[7:0];
    assign blk       = bus_addr[ADDR_W-1 -: BLK_W];
    assign tmr_run   = (q.state == ST_BUSY);
    assign bus_rdata = q.rdata;
    assign status    = {q.state != ST_BUSY, 2'b00, q.sr_pfail, q.sr_vpp,
                        q.state == ST_SUSP, q.sr_lock, 1'b0};

    always_comb begin
        d        = q;
        tmr_load = 1'b0;
        prog_en  = 1'b0;
        unique case (q.state)
            ST_IDLE: if (bus_we) begin
                case (cmd)
                    CMD_PROG:  begin d.state = ST_SETUP; d.rmode = RD_STATUS; end
                    CMD_RDSR:  d.rmode = RD_STATUS;
                    CMD_CLRSR: begin d.sr_pfail = 1'b0; d.sr_vpp = 1'b0; d.sr_lock = 1'b0; end
                    CMD_IDENT: d.rmode = RD_IDENT;
                    CMD_RDARR: d.rmode = RD_ARRAY;
                    default: ;
                endcase
            end
            ST_SETUP: if (bus_we) begin
                d.rmode = RD_STATUS;
                d.state = ST_IDLE;
                if (!vpp_ok)            d.sr_vpp  = 1'b1;
                else if (blk_lock[blk]) d.sr_lock = 1'b1;
                else begin
                    d.tgt_addr = bus_addr;
                    d.tgt_data = bus_wdata;
                    d.state    = ST_BUSY;
                    tmr_load   = 1'b1;
                end
            end
            ST_BUSY: begin
                if (tmr_done) begin
                    d.state = ST_IDLE;
                    if (fail_inj) d.sr_pfail = 1'b1;
                    else          prog_en    = 1'b1;
                end else if (bus_we) begin
                    case (cmd)
                        CMD_SUSP:  d.state = ST_SUSP;
                        CMD_RDSR:  d.rmode = RD_STATUS;
                        CMD_IDENT: d.rmode = RD_IDENT;
                        CMD_RDARR: d.rmode = RD_ARRAY;
                        default: ;
                    endcase
                end
            end
            ST_SUSP: if (bus_we) begin
                case (cmd)
                    CMD_RESUME: begin d.state = ST_BUSY; d.rmode = RD_STATUS; end
                    CMD_RDSR:   d.rmode = RD_STATUS;
                    CMD_IDENT:  d.rmode = RD_IDENT;
                    CMD_RDARR:  d.rmode = RD_ARRAY;
                    default: ;
                endcase
            end
            default: d.state = ST_IDLE;
        endcase

        if (bus_re) begin
            case (q.rmode)
                RD_STATUS: d.rdata = {{(DATA_W-8){1'b0}}, status};
                RD_IDENT:  d.rdata = bus_addr[0] ? DATA_W'(DEV_ID) : DATA_W'(MFR_ID);
                default:   d.rdata = (q.state == ST_BUSY) ? DATA_W'(FILL) : arr_word;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.state    <= ST_IDLE;
            q.rmode    <= RD_ARRAY;
        end else begin
            q <= d;
        end
    end

    fpc_timer #(.PROG_CYC(PROG_CYC)) timer_i (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .run(tmr_run), .done(tmr_done)
    );

    fpc_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
        .clk(clk), .rst_n(rst_n), .rd_addr(bus_addr), .rd_word(arr_word),
        .prog_en(prog_en), .prog_addr(q.tgt_addr), .prog_data(q.tgt_data),
        .old_word(old_word)
    );

    // R4
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_done |-> (q.state == ST_BUSY));
    // R5
    vpp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.sr_vpp) |-> $past(q.state == ST_SETUP && bus_we && !vpp_ok));
    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.sr_pfail) |-> $past(bus_we && cmd == CMD_CLRSR && q.state == ST_IDLE));
endmodule

// File: tb/flash_prog_ctrl_tb_top.sv
module flash_prog_ctrl_tb_top;
    localparam int N = 8;
    localparam logic [15:0] MFR = 16'h0051, DEV = 16'h7E21, FIL = 16'hDEAD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [15:0] bus_rdata;
    logic        vpp_ok = 1'b1;
    logic [3:0]  blk_lock = '0;
    logic        fail_inj = 1'b0;
    int checks = 0, errors = 0;
    logic [15:0] v;

    always #10 clk = ~clk;

    flash_prog_ctrl #(.PROG_CYC(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .vpp_ok(vpp_ok), .blk_lock(blk_lock), .fail_inj(fail_inj)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a negedge; the write is sampled at the next posedge
    task automatic wr(input logic [5:0] a, input logic [15:0] dv);
        bus_addr = a; bus_wdata = dv; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] o);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        o = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_err;
        wr(0, 16'h0050); wr(0, 16'h00FF);
    endtask

    task automatic t_reset;
        rd(6'd12, v); chk("R1 array after reset", v, 16'hFFFF);
        wr(0, 16'h0070);
        rd(0, v); chk("R1 status after reset", v, 16'h0080);
        wr(0, 16'h00FF);
    endtask

    task automatic t_program;
        wr(3, 16'h0040); wr(3, 16'h0F0F);
        rd(6'd40, v); chk("R3 status at other address", v, 16'h0000);
        idle(N - 2);
        rd(3, v); chk("R4 still busy on last cycle", v, 16'h0000);
        rd(3, v); chk("R4 ready after run", v, 16'h0080);
        wr(0, 16'h00FF);
        rd(3, v); chk("R2 first program", v, 16'h0F0F);
        wr(3, 16'h0040); wr(3, 16'hF0FF);
        idle(N + 1);
        wr(0, 16'h00FF);
        rd(3, v); chk("R2 ones never set", v, 16'h000F);
    endtask

    task automatic t_vpp;
        vpp_ok = 1'b0;
        wr(5, 16'h0040); wr(5, 16'h0000);
        rd(5, v); chk("R5 supply error no busy", v, 16'h0088);
        vpp_ok = 1'b1;
        wr(0, 16'h00FF); wr(0, 16'h0070);
        rd(0, v); chk("R8 error held", v, 16'h0088);
        wr(0, 16'h00FF);
        rd(5, v); chk("R5 array untouched", v, 16'hFFFF);
        wr(0, 16'h0050); wr(0, 16'h0070);
        rd(0, v); chk("R8 cleared", v, 16'h0080);
        wr(0, 16'h00FF);
    endtask

    task automatic t_lock;
        blk_lock = 4'b0100;
        wr(6'h25, 16'h0040); wr(6'h25, 16'h0000);
        rd(0, v); chk("R6 locked abort", v, 16'h0082);
        wr(0, 16'h00FF);
        rd(6'h25, v); chk("R6 array untouched", v, 16'hFFFF);
        blk_lock = '0;
        clear_err();
    endtask

    task automatic t_fail;
        fail_inj = 1'b1;
        wr(7, 16'h0040); wr(7, 16'h0000);
        idle(N + 1);
        rd(0, v); chk("R7 program fail bit", v, 16'h0090);
        fail_inj = 1'b0;
        wr(0, 16'h00FF);
        rd(7, v); chk("R7 array untouched", v, 16'hFFFF);
        clear_err();
    endtask

    task automatic t_busy_cmds;
        vpp_ok = 1'b0;
        wr(1, 16'h0040); wr(1, 16'h0000);
        vpp_ok = 1'b1;
        wr(8, 16'h0040); wr(8, 16'h1234);
        wr(0, 16'h0050); wr(0, 16'h0040); wr(0, 16'h00FF);
        rd(8, v); chk("R9 filler while busy", v, FIL);
        idle(N);
        rd(8, v); chk("R9 array after run", v, 16'h1234);
        wr(0, 16'h0070);
        rd(0, v); chk("R9 clear ignored while busy", v, 16'h0088);
        wr(0, 16'h0090);
        rd(0, v); chk("R9 setup ignored while busy", v, MFR);
        clear_err();
    endtask

    task automatic t_ident;
        wr(0, 16'h0090);
        rd(0, v); chk("R11 maker id", v, MFR);
        rd(1, v); chk("R11 device id", v, DEV);
        rd(2, v); chk("R11 even address", v, MFR);
        wr(0, 16'h00FF);
        idle(2);
        chk("R12 output held without strobe", bus_rdata, MFR);
        rd(2, v); chk("R12 updates on strobe", v, 16'hFFFF);
    endtask

    task automatic t_suspend;
        wr(9, 16'h0040); wr(9, 16'h00F0);
        wr(0, 16'h00B0);
        rd(0, v); chk("R10 suspended status", v, 16'h0084);
        idle(20);
        rd(0, v); chk("R10 still suspended", v, 16'h0084);
        wr(0, 16'h00FF);
        rd(9, v); chk("R10 array unchanged in suspend", v, 16'hFFFF);
        wr(0, 16'h00D0);
        idle(N - 2);
        rd(0, v); chk("R10 resumed remaining cycles busy", v, 16'h0000);
        rd(0, v); chk("R10 resumed run ends", v, 16'h0080);
        wr(0, 16'h00FF);
        rd(9, v); chk("R10 program after resume", v, 16'h00F0);
    endtask

    task automatic t_collide;
        wr(10, 16'h0040); wr(10, 16'h0000);
        idle(N - 1);
        wr(0, 16'h00B0);
        rd(0, v); chk("R10 completion beats suspend", v, 16'h0080);
        wr(0, 16'h00FF);
        rd(10, v); chk("R10 collision word programmed", v, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_vpp();
        t_lock();
        t_fail();
        t_busy_cmds();
        t_ident();
        t_suspend();
        t_collide();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule